// File: doc/BRIEF.md
# Receive Signaling Register Bank with Alarm-Driven Freeze

This block keeps the latest robbed-bit signaling values of one T1/J1 receive channel in twelve byte-wide registers. The framer delivers each signaling byte through a write strobe with an address and data. A host reads any register through a combinational read port.

Three receive-side conditions suspend updates so that stale or corrupted signaling never overwrites good values: loss of signal, loss of multiframe alignment, and a receive slip. The first two are levels. A slip is a single-cycle pulse that holds the freeze for one full multiframe, counted as 24 frame ticks after the pulse. While frozen, the bank keeps its contents and drops incoming writes. A configuration input turns automatic freezing off altogether. The freeze state is exported as a status output.

Top module: `sig_freeze_bank`

## Requirements
- R1: While rst_ni is low, all twelve registers read as zero and frozen_o is 0.
- R2: When frozen_o is 0, a write strobe to address 0..11 stores sig_data_i in that register, and it reads back on rd_data_o from the next cycle on.
- R3: While los_i is 1 and frz_dis_i is 0, frozen_o is 1 in the same cycle, and writes are discarded.
- R4: While lomf_i is 1 and frz_dis_i is 0, frozen_o is 1 in the same cycle, and writes are discarded.
- R5: A slip_i pulse sets frozen_o to 1 in the pulse cycle. Freezing continues until 24 frame_tick_i pulses have been seen after the pulse, and frozen_o returns to 0 in the cycle after the 24th tick. Writes made during this hold are discarded.
- R6: A slip_i pulse that arrives during a hold, including one in the same cycle as a frame tick, restarts the hold at a full 24 ticks.
- R7: While frz_dis_i is 1, frozen_o is 0 and writes are accepted whatever the alarm inputs are.
- R8: The first write in a cycle where all enabled triggers have cleared is accepted.
- R9: Writes to addresses 12..15 change no register. Reads of addresses 12..15 return zero.
- R10: While frozen, every register keeps its value and stays readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sig_we_i | input | 1 | Signaling write strobe |
| sig_addr_i | input | 4 | Signaling register index |
| sig_data_i | input | 8 | Signaling write data |
| frame_tick_i | input | 1 | One pulse per received frame |
| los_i | input | 1 | Loss of signal (level) |
| lomf_i | input | 1 | Loss of multiframe alignment (level) |
| slip_i | input | 1 | Receive slip (pulse) |
| frz_dis_i | input | 1 | 1 = automatic freezing disabled |
| rd_addr_i | input | 4 | Host read index |
| rd_data_o | output | 8 | Host read data |
| frozen_o | output | 1 | Freeze status |

## Verification
Two events can land on the same edge: a new slip pulse and the frame tick that would otherwise shorten the hold. The bench provokes this by raising slip_i together with frame_tick_i ten ticks into a hold. It then judges that exactly 24 further ticks are needed before frozen_o drops. A second collision is a write issued in the very cycle the last trigger clears. That write must land, and a write issued one tick earlier must be lost.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  localparam int unsigned SFB_NUM_REGS    = 12;
  localparam int unsigned SFB_DATA_W      = 8;
  localparam int unsigned SFB_SLIP_FRAMES = 24;

  typedef struct packed {
    logic los;
    logic lomf;
    logic slip;
  } frz_trig_t;
endpackage

// File: rtl/sfb_slip_timer.sv
module sfb_slip_timer #(
  parameter int unsigned HOLD = 24,
  localparam int unsigned CW = $clog2(HOLD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slip_i,
  input  logic frame_tick_i,
  output logic hold_o
);
  logic [CW-1:0] cnt_q;

  // reload wins over a coincident tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (slip_i)                      cnt_q <= CW'(HOLD);
    else if (frame_tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign hold_o = slip_i | (cnt_q != '0);

  // R6
  slip_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_i |=> cnt_q == CW'(HOLD));
  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(HOLD));
  // R5
  tick_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_tick_i && !slip_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/sfb_freeze_ctrl.sv
module sfb_freeze_ctrl
  import sfb_pkg::*;
(
  input  frz_trig_t trig_i,
  input  logic      dis_i,
  output logic      frz_o
);
  always_comb begin
    frz_o = 1'b0;
    if (!dis_i) frz_o = trig_i.los | trig_i.lomf | trig_i.slip;
  end
endmodule

// File: rtl/sfb_reg_bank.sv
module sfb_reg_bank #(
  parameter int unsigned NUM_REGS = 12,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned AW = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              hold_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] reg_q [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic wr_en;
    assign wr_en = we_i & ~hold_i & (addr_i == AW'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    reg_q[k] <= '0;
      else if (wr_en) reg_q[k] <= data_i;
    end

    // R10
    hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_i |=> $stable(reg_q[k]));
    // R2
    write_land_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !hold_i && addr_i == AW'(k)) |=> reg_q[k] == $past(data_i));
  end

  // out-of-range index reads zero
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr_i == AW'(i)) rd_data_o = reg_q[i];
  end

  // R9
  oor_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i >= AW'(NUM_REGS)) |-> rd_data_o == '0);
endmodule

// File: rtl/sig_freeze_bank.sv
module sig_freeze_bank
  import sfb_pkg::*;
#(
  parameter int unsigned NUM_REGS    = SFB_NUM_REGS,
  parameter int unsigned DATA_W      = SFB_DATA_W,
  parameter int unsigned SLIP_FRAMES = SFB_SLIP_FRAMES,
  localparam int unsigned AW = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sig_we_i,
  input  logic [AW-1:0]     sig_addr_i,
  input  logic [DATA_W-1:0] sig_data_i,
  input  logic              frame_tick_i,
  input  logic              los_i,
  input  logic              lomf_i,
  input  logic              slip_i,
  input  logic              frz_dis_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              frozen_o
);
  logic      slip_hold;
  frz_trig_t trig;

  sfb_slip_timer #(.HOLD(SLIP_FRAMES)) u_slip (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slip_i       (slip_i),
    .frame_tick_i (frame_tick_i),
    .hold_o       (slip_hold)
  );

  assign trig = '{los: los_i, lomf: lomf_i, slip: slip_hold};

  sfb_freeze_ctrl u_ctrl (
    .trig_i (trig),
    .dis_i  (frz_dis_i),
    .frz_o  (frozen_o)
  );

  sfb_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (sig_we_i),
    .hold_i    (frozen_o),
    .addr_i    (sig_addr_i),
    .data_i    (sig_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  // R3
  los_frz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (los_i && !frz_dis_i) |-> frozen_o);
  // R4
  lomf_frz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lomf_i && !frz_dis_i) |-> frozen_o);
  // R5
  slip_frz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_i |=> (frozen_o || frz_dis_i));
  // R7
  dis_frz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_dis_i |-> !frozen_o);
endmodule

// File: tb/sig_freeze_bank_tb.sv
module sig_freeze_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sig_we_i = 1'b0;
  logic [3:0] sig_addr_i = '0;
  logic [7:0] sig_data_i = '0;
  logic       frame_tick_i = 1'b0;
  logic       los_i = 1'b0;
  logic       lomf_i = 1'b0;
  logic       slip_i = 1'b0;
  logic       frz_dis_i = 1'b0;
  logic [3:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       frozen_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_freeze_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sig_we_i(sig_we_i), .sig_addr_i(sig_addr_i),
    .sig_data_i(sig_data_i), .frame_tick_i(frame_tick_i), .los_i(los_i),
    .lomf_i(lomf_i), .slip_i(slip_i), .frz_dis_i(frz_dis_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .frozen_o(frozen_o)
  );

  // we | addr | data | los | lomf | dis | rd_addr | exp_rd | exp_frz
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 4'd0,  8'hA5, 1'b0, 1'b0, 1'b0, 4'd0,  8'hA5, 1'b0}, // R2
    {1'b1, 4'd11, 8'h3C, 1'b0, 1'b0, 1'b0, 4'd11, 8'h3C, 1'b0}, // R2
    {1'b1, 4'd5,  8'h77, 1'b1, 1'b0, 1'b0, 4'd5,  8'h00, 1'b1}, // R3
    {1'b0, 4'd0,  8'h00, 1'b1, 1'b0, 1'b0, 4'd0,  8'hA5, 1'b1}, // R10
    {1'b1, 4'd0,  8'hFF, 1'b0, 1'b1, 1'b0, 4'd0,  8'hA5, 1'b1}, // R4
    {1'b1, 4'd0,  8'h11, 1'b1, 1'b0, 1'b1, 4'd0,  8'h11, 1'b0}, // R7
    {1'b1, 4'd1,  8'h22, 1'b0, 1'b1, 1'b1, 4'd1,  8'h22, 1'b0}, // R7
    {1'b1, 4'd5,  8'h99, 1'b0, 1'b0, 1'b0, 4'd5,  8'h99, 1'b0}, // R8
    {1'b1, 4'd12, 8'hEE, 1'b0, 1'b0, 1'b0, 4'd12, 8'h00, 1'b0}, // R9
    {1'b1, 4'd15, 8'hEE, 1'b0, 1'b0, 1'b0, 4'd11, 8'h3C, 1'b0}, // R9
    {1'b1, 4'd2,  8'h5A, 1'b1, 1'b1, 1'b0, 4'd2,  8'h00, 1'b1}  // R3 R4
  };
  localparam string VTAG [NV] = '{"R2", "R2", "R3", "R10", "R4", "R7", "R7",
                                  "R8", "R9", "R9", "R3"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    sig_we_i = 1'b1; sig_addr_i = a; sig_data_i = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    for (int a = 0; a < 12; a++) begin
      rd_addr_i = 4'(a); #1;
      chk("R1", 32'(rd_data_o), 32'h0);
    end
    chk("R1", 32'(frozen_o), 32'h0);
    rst_ni = 1'b1;
    step();

    for (int v = 0; v < NV; v++) begin
      sig_we_i   = VEC[v][28];
      sig_addr_i = VEC[v][27:24];
      sig_data_i = VEC[v][23:16];
      los_i      = VEC[v][15];
      lomf_i     = VEC[v][14];
      frz_dis_i  = VEC[v][13];
      rd_addr_i  = VEC[v][12:9];
      step();
      chk(VTAG[v], 32'(frozen_o), 32'(VEC[v][0]));
      chk(VTAG[v], 32'(rd_data_o), 32'(VEC[v][8:1]));
    end
    sig_we_i = 1'b0; los_i = 1'b0; lomf_i = 1'b0; frz_dis_i = 1'b0;

    // R5 slip hold, write in pulse cycle lost
    rd_addr_i = 4'd3;
    slip_i = 1'b1; wr(4'd3, 8'h44); #1;
    chk("R5", 32'(frozen_o), 32'h1);
    step();
    slip_i = 1'b0; sig_we_i = 1'b0;
    chk("R5", 32'(rd_data_o), 32'h0);
    frame_tick_i = 1'b1;
    repeat (23) step();
    frame_tick_i = 1'b0;
    chk("R5", 32'(frozen_o), 32'h1);
    wr(4'd3, 8'h55); step(); sig_we_i = 1'b0;
    chk("R5", 32'(rd_data_o), 32'h0);
    frame_tick_i = 1'b1; step(); frame_tick_i = 1'b0;
    chk("R5", 32'(frozen_o), 32'h0);
    // R8 first write after release lands
    wr(4'd3, 8'h66); step(); sig_we_i = 1'b0;
    chk("R8", 32'(rd_data_o), 32'h66);

    // R6 retrigger together with a tick
    slip_i = 1'b1; step(); slip_i = 1'b0;
    frame_tick_i = 1'b1;
    repeat (10) step();
    slip_i = 1'b1; step(); slip_i = 1'b0;
    repeat (23) step();
    frame_tick_i = 1'b0;
    chk("R6", 32'(frozen_o), 32'h1);
    frame_tick_i = 1'b1; step(); frame_tick_i = 1'b0;
    chk("R6", 32'(frozen_o), 32'h0);

    // R7 disable overrides slip hold
    rd_addr_i = 4'd4;
    slip_i = 1'b1; frz_dis_i = 1'b1; wr(4'd4, 8'h77); #1;
    chk("R7", 32'(frozen_o), 32'h0);
    step();
    slip_i = 1'b0; sig_we_i = 1'b0;
    chk("R7", 32'(rd_data_o), 32'h77);
    frz_dis_i = 1'b0; #1;
    chk("R5", 32'(frozen_o), 32'h1);

    // R1 reset during hold clears bank and freeze
    rst_ni = 1'b0; #1;
    chk("R1", 32'(frozen_o), 32'h0);
    chk("R1", 32'(rd_data_o), 32'h0);
    rd_addr_i = 4'd0; #1;
    chk("R1", 32'(rd_data_o), 32'h0);
    step();
    rst_ni = 1'b1;
    step();
    chk("R1", 32'(frozen_o), 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule